// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Pipeline

This block adds or subtracts two 32-bit binary floating-point numbers in the common single-precision interchange format. It has a fixed three-rank pipeline with no stall path. A caller presents two operands, an operation select, a rounding direction and a valid strobe in any cycle. The rounded sum, its valid flag and four exception flags come out together exactly three cycles later. Because nothing ever waits, a new operation can be issued in every cycle.

Inside the pipeline, the first rank classifies the operands. It orders them by magnitude and shifts the smaller significand right, keeping guard, round and sticky bits. The second rank adds or subtracts the significands and renormalises. The third rank rounds the result in the direction chosen for that operation, then packs it and raises the flags. Denormal numbers are not supported: a denormal input counts as a zero of the same sign, and any result below the normal range is replaced by zero.

Top module: `fpadd_pipe`

## Requirements
- R1: `in_op` = 0 selects a + b and `in_op` = 1 selects a − b. Subtraction is computed as a plus b with the sign of b inverted.
- R2: Operands presented with `in_valid` high in cycle c are captured at the rising edge that ends cycle c. Their result is on `out_res`/`out_flags`, with `out_valid` high, during cycle c+3. In any cycle whose cycle c−3 had no valid input, `out_valid` is low.
- R3: Valid operations may be issued in consecutive cycles without gaps. Every one of them is returned in order, one per cycle.
- R4: Finite normal results are correctly rounded to 24 significant bits according to `in_rm`: 00 = to nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward −infinity.
- R5: An operand whose exponent field is 0 is treated as a zero with its own sign. `out_res` never carries an exponent field of 0 together with a nonzero fraction.
- R6: If either operand is a NaN, or if the sum is infinity plus an infinity of opposite sign, the result is 0x7FC00000 and the only flag set is invalid.
- R7: In all other cases where an infinity is present, the result is that infinity and no flag is set.
- R8: An exactly zero sum is +0, except under mode 11, where it is −0. The exception is when both operands are zeros of the same effective sign; then the result keeps that sign. No flag is set in either case.
- R9: If the rounded exponent exceeds 254, the overflow and inexact flags are set. The result is infinity when the mode is 00 or rounds away from zero for that sign; otherwise it is the largest finite value of that sign.
- R10: If a nonzero result has a rounded exponent below 1, it becomes a zero with the result's sign, and both underflow and inexact are set.
- R11: `out_flags` bit 3 is invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact. For an in-range finite result, inexact is set exactly when rounding discarded nonzero bits.
- R12: While `rst_n` is low, and until a valid operation has gone through the pipeline, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 1 | 0 = add, 1 = subtract |
| in_rm | input | 2 | Rounding direction for this operation |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result valid |
| out_res | output | 32 | Rounded result |
| out_flags | output | 4 | {invalid, overflow, underflow, inexact} |

## Verification
Every result is due in the third cycle after the cycle in which its operands were presented, whether the operation is a normal sum or a special case. When the bench issues an operation, it computes that due cycle from a free-running edge counter and stores it in the scoreboard entry with the expected value. The monitor samples on the falling edge. It rejects a valid output that arrives in any other cycle, arrives with the queue empty, or fails to appear when its entry falls due. The expected sums come from an exact wide-integer model that rounds by comparing the remainder against a half unit, so the guard/round/sticky datapath is never copied into the bench.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;        // significand with hidden one
  localparam int ALN_W  = SIG_W + 3;         // plus guard, round, sticky
  localparam int SUM_W  = ALN_W + 1;         // plus carry
  localparam int XE_W   = EXP_W + 2;         // signed working exponent
  localparam int LZ_W   = $clog2(ALN_W + 1);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0]  EXP_ALL1 = '1;
  localparam logic [WORD_W-1:0] QNAN_W   = {1'b0, EXP_ALL1, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rmode_e;

  typedef struct packed {
    logic              vld;
    rmode_e            rm;
    logic              spec;
    logic              spec_nv;
    logic [WORD_W-1:0] spec_res;
    logic              sgn;
    logic              sub;
    logic [EXP_W-1:0]  exp;
    logic [ALN_W-1:0]  ma;
    logic [ALN_W-1:0]  mb;
  } align_t;

  typedef struct packed {
    logic              vld;
    rmode_e            rm;
    logic              spec;
    logic              spec_nv;
    logic [WORD_W-1:0] spec_res;
    logic              sgn;
    logic              zero;
    logic [XE_W-1:0]   exp;
    logic [ALN_W-1:0]  man;
  } norm_t;

  function automatic logic f_is_nan(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2 -: EXP_W] == EXP_ALL1) && (w[FRAC_W-1:0] != '0);
  endfunction

  function automatic logic f_is_inf(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2 -: EXP_W] == EXP_ALL1) && (w[FRAC_W-1:0] == '0);
  endfunction

  // Right shift of the smaller significand; everything below the round bit
  // is folded into the sticky bit.
  function automatic logic [ALN_W-1:0] f_align(input logic [SIG_W-1:0] m,
                                               input logic [EXP_W-1:0] d);
    logic [SIG_W+ALN_W-2:0] w;
    if (d >= EXP_W'(ALN_W - 1)) return {{(ALN_W-1){1'b0}}, |m};
    w = {m, {(ALN_W-1){1'b0}}} >> d;
    return {w[SIG_W+ALN_W-2 -: ALN_W-1], |w[SIG_W-1:0]};
  endfunction

  function automatic logic [LZ_W-1:0] f_lzc(input logic [ALN_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n    = '0;
    seen = 1'b0;
    for (int i = ALN_W - 1; i >= 0; i--) begin
      if (v[i]) seen = 1'b1;
      else if (!seen) n = n + 1'b1;
    end
    return n;
  endfunction

  function automatic logic f_round_up(input rmode_e rm, input logic sgn,
                                      input logic lsb, input logic g,
                                      input logic st);
    case (rm)
      RM_NEAR: return g & (st | lsb);
      RM_ZERO: return 1'b0;
      RM_PINF: return (g | st) & ~sgn;
      default: return (g | st) & sgn;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_ovf_value(input rmode_e rm, input logic sgn);
    logic to_inf;
    to_inf = (rm == RM_NEAR) || (rm == RM_PINF && !sgn) || (rm == RM_NINF && sgn);
    if (to_inf) return {sgn, EXP_ALL1, {FRAC_W{1'b0}}};
    return {sgn, EXP_ALL1 - 1'b1, {FRAC_W{1'b1}}};
  endfunction

endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic [1:0]        in_rm,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output align_t            s1
);

  logic              sa, sb;
  logic              nan_a, nan_b, inf_a, inf_b;
  logic [WORD_W-2:0] mag_a, mag_b, big, sml;
  logic              swap;
  logic [SIG_W-1:0]  sig_big, sig_sml;
  align_t            nx;

  always_comb begin
    sa    = in_a[WORD_W-1];
    sb    = in_b[WORD_W-1] ^ in_op;
    nan_a = f_is_nan(in_a);
    nan_b = f_is_nan(in_b);
    inf_a = f_is_inf(in_a);
    inf_b = f_is_inf(in_b);

    // denormal inputs flush to zero, sign kept
    mag_a = (in_a[WORD_W-2 -: EXP_W] == '0) ? '0 : in_a[WORD_W-2:0];
    mag_b = (in_b[WORD_W-2 -: EXP_W] == '0) ? '0 : in_b[WORD_W-2:0];
    swap  = mag_b > mag_a;
    big   = swap ? mag_b : mag_a;
    sml   = swap ? mag_a : mag_b;

    sig_big = (big[WORD_W-2 -: EXP_W] == '0) ? '0 : {1'b1, big[FRAC_W-1:0]};
    sig_sml = (sml[WORD_W-2 -: EXP_W] == '0) ? '0 : {1'b1, sml[FRAC_W-1:0]};

    nx          = '0;
    nx.vld      = in_valid;
    nx.rm       = rmode_e'(in_rm);
    nx.sgn      = swap ? sb : sa;
    nx.sub      = sa ^ sb;
    nx.exp      = big[WORD_W-2 -: EXP_W];
    nx.ma       = {sig_big, 3'b000};
    nx.mb       = f_align(sig_sml, big[WORD_W-2 -: EXP_W] - sml[WORD_W-2 -: EXP_W]);

    if (nan_a || nan_b) begin
      nx.spec     = 1'b1;
      nx.spec_nv  = 1'b1;
      nx.spec_res = QNAN_W;
    end else if (inf_a && inf_b) begin
      nx.spec = 1'b1;
      if (sa != sb) begin
        nx.spec_nv  = 1'b1;
        nx.spec_res = QNAN_W;
      end else begin
        nx.spec_res = {sa, EXP_ALL1, {FRAC_W{1'b0}}};
      end
    end else if (inf_a) begin
      nx.spec     = 1'b1;
      nx.spec_res = {sa, EXP_ALL1, {FRAC_W{1'b0}}};
    end else if (inf_b) begin
      nx.spec     = 1'b1;
      nx.spec_res = {sb, EXP_ALL1, {FRAC_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1 <= '0;
    else        s1 <= nx;
  end

  // R4: the larger-magnitude operand always sits on the unshifted side
  a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
    (s1.vld && !s1.spec) |-> (s1.ma >= s1.mb));

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
  import fpadd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  align_t s1,
  output norm_t  s2
);

  logic [SUM_W-1:0]       sum;
  logic [LZ_W-1:0]        lz;
  logic signed [XE_W-1:0] ebig;
  norm_t                  nx;

  always_comb begin
    sum  = s1.sub ? ({1'b0, s1.ma} - {1'b0, s1.mb}) : ({1'b0, s1.ma} + {1'b0, s1.mb});
    lz   = f_lzc(sum[ALN_W-1:0]);
    ebig = $signed({2'b00, s1.exp});

    nx          = '0;
    nx.vld      = s1.vld;
    nx.rm       = s1.rm;
    nx.spec     = s1.spec;
    nx.spec_nv  = s1.spec_nv;
    nx.spec_res = s1.spec_res;
    nx.zero     = (sum == '0);

    if (sum[SUM_W-1]) begin
      nx.man = {sum[SUM_W-1:2], |sum[1:0]};
      nx.exp = ebig + 10'sd1;
    end else begin
      nx.man = sum[ALN_W-1:0] << lz;
      nx.exp = ebig - $signed({{(XE_W-LZ_W){1'b0}}, lz});
    end

    // exact zero: same-sign zeros keep the sign, cancellation follows the mode
    if (nx.zero) nx.sgn = s1.sub ? (s1.rm == RM_NINF) : s1.sgn;
    else         nx.sgn = s1.sgn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2 <= '0;
    else        s2 <= nx;
  end

  // R4: a nonzero finite sum leaves this rank with its leading one in place
  a_r4_norm_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (s2.vld && !s2.spec && !s2.zero) |-> s2.man[ALN_W-1]);

endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
  import fpadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  norm_t             s2,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_res,
  output logic [3:0]        out_flags
);

  logic                   lsb, g, st, inexact, up;
  logic [SIG_W:0]         sig;
  logic signed [XE_W-1:0] erd;
  logic [FRAC_W-1:0]      frac;
  logic [WORD_W-1:0]      res_n;
  logic [3:0]             flg_n;

  always_comb begin
    lsb     = s2.man[3];
    g       = s2.man[2];
    st      = |s2.man[1:0];
    inexact = g | st;
    up      = f_round_up(s2.rm, s2.sgn, lsb, g, st);
    sig     = {1'b0, s2.man[ALN_W-1:3]} + {{SIG_W{1'b0}}, up};
    erd     = $signed(s2.exp) + $signed({{(XE_W-1){1'b0}}, sig[SIG_W]});
    frac    = sig[SIG_W] ? sig[SIG_W-1:1] : sig[FRAC_W-1:0];

    if (s2.spec) begin
      res_n = s2.spec_res;
      flg_n = {s2.spec_nv, 3'b000};
    end else if (s2.zero) begin
      res_n = {s2.sgn, {(WORD_W-1){1'b0}}};
      flg_n = 4'b0000;
    end else if (erd >= $signed(XE_W'(2**EXP_W - 1))) begin
      res_n = f_ovf_value(s2.rm, s2.sgn);
      flg_n = 4'b0101;
    end else if (erd <= 10'sd0) begin
      res_n = {s2.sgn, {(WORD_W-1){1'b0}}};
      flg_n = 4'b0011;
    end else begin
      res_n = {s2.sgn, erd[EXP_W-1:0], frac};
      flg_n = {3'b000, inexact};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= s2.vld;
      out_res   <= res_n;
      out_flags <= flg_n;
    end
  end

  a_r6_canon_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[3]) |-> (out_res == QNAN_W && out_flags[2:0] == 3'b000));

  a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[2]) |-> (out_flags[0] && out_res[WORD_W-2 -: EXP_W] >= (EXP_ALL1 - 1'b1)));

  a_r10_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[1]) |-> (out_flags[0] && out_res[WORD_W-2:0] == '0));

  a_r5_no_denormal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_res[WORD_W-2 -: EXP_W] == '0 && out_res[FRAC_W-1:0] != '0));

endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_op,
  input  logic [1:0]  in_rm,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  output logic        out_valid,
  output logic [31:0] out_res,
  output logic [3:0]  out_flags
);

  align_t     s1;
  norm_t      s2;
  logic [1:0] warm;

  fpadd_align u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_rm    (in_rm),
    .in_a     (in_a),
    .in_b     (in_b),
    .s1       (s1)
  );

  fpadd_norm u_norm (
    .clk   (clk),
    .rst_n (rst_n),
    .s1    (s1),
    .s2    (s2)
  );

  fpadd_round u_round (
    .clk       (clk),
    .rst_n     (rst_n),
    .s2        (s2),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_flags (out_flags)
  );

  // cycles since reset, saturating, used only to keep $past inside that window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm <= 2'd0;
    else if (warm != 2'd3)   warm <= warm + 2'd1;
  end

  // R2 / R3: every strobe comes back exactly three cycles on, one per cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r12_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd3) |-> !out_valid);

endmodule

// File: tb/fpadd_pipe_tb_top.sv
`timescale 1ns/1ps
module fpadd_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [1:0]  in_rm = 2'b00;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_res;
  logic [3:0]  out_flags;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;
    int          due;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  fpadd_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_rm(in_rm),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res), .out_flags(out_flags)
  );

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Exact model: each operand becomes an integer count of 2^-149 units,
  // the signed sum is formed exactly, then rounded by remainder comparison.
  function automatic void model(input logic [31:0] a, input logic [31:0] b, input logic op,
                                input logic [1:0] rm, output logic [31:0] r, output logic [3:0] f);
    logic         sa, sb, sr, nx, up;
    logic [279:0] va, vb, mag, q, rem, half;
    int           p, sh, e;
    sa = a[31]; sb = b[31] ^ op;
    f  = 4'b0000;
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) begin
      r = 32'h7FC00000; f = 4'b1000; return;
    end
    if (a[30:23] == 8'hFF && b[30:23] == 8'hFF) begin
      if (sa != sb) begin r = 32'h7FC00000; f = 4'b1000; end
      else r = {sa, 8'hFF, 23'h0};
      return;
    end
    if (a[30:23] == 8'hFF) begin r = {sa, 8'hFF, 23'h0}; return; end
    if (b[30:23] == 8'hFF) begin r = {sb, 8'hFF, 23'h0}; return; end
    va = (a[30:23] == 0) ? 280'd0 : (280'({1'b1, a[22:0]}) << (int'(a[30:23]) - 1));
    vb = (b[30:23] == 0) ? 280'd0 : (280'({1'b1, b[22:0]}) << (int'(b[30:23]) - 1));
    if (sa == sb)      begin mag = va + vb; sr = sa; end
    else if (va >= vb) begin mag = va - vb; sr = sa; end
    else               begin mag = vb - va; sr = sb; end
    if (mag == 0) begin
      sr = (sa == sb) ? sa : (rm == 2'b11);
      r = {sr, 31'h0}; return;
    end
    p = 0;
    for (int i = 0; i < 280; i++) if (mag[i]) p = i;
    if (p < 23) begin r = {sr, 31'h0}; f = 4'b0011; return; end
    sh   = p - 23;
    q    = mag >> sh;
    rem  = mag - (q << sh);
    half = (sh == 0) ? 280'd0 : (280'd1 << (sh - 1));
    nx   = (rem != 0);
    case (rm)
      2'b00:   up = (rem > half) || (sh > 0 && rem == half && q[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = nx && !sr;
      default: up = nx && sr;
    endcase
    q = q + 280'(up);
    e = sh + 1;
    if (q[24]) begin q = q >> 1; e++; end
    if (e >= 255) begin
      f = 4'b0101;
      if (rm == 2'b00 || (rm == 2'b10 && !sr) || (rm == 2'b11 && sr)) r = {sr, 8'hFF, 23'h0};
      else r = {sr, 8'hFE, 23'h7FFFFF};
      return;
    end
    r = {sr, 8'(e), q[22:0]};
    f = {3'b000, nx};
  endfunction

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic op,
                       input logic [1:0] rm, input string tag);
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_rm = rm; in_a = a; in_b = b;
    model(a, b, op, rm, it.res, it.fl);
    it.due = cyc + 3;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard as results come out
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (sbq.size() == 0) begin
          note(1'b0, "R2", "unexpected valid", 36'(cyc), 36'(0));
        end else begin
          exp_t it;
          it = sbq.pop_front();
          note(it.due == cyc, it.tag, "R2 due cycle", 36'(cyc), 36'(it.due));
          note(out_res == it.res, it.tag, "result", 36'(out_res), 36'(it.res));
          note(out_flags == it.fl, it.tag, "R11 flags", 36'(out_flags), 36'(it.fl));
        end
      end else if (sbq.size() > 0 && sbq[0].due <= cyc) begin
        exp_t it;
        it = sbq.pop_front();
        note(1'b0, it.tag, "R2 missing result", 36'(cyc), 36'(it.due));
      end
    end
  end

  function automatic logic [31:0] rnd_word(input int emode, input logic [7:0] near);
    int e;
    case (emode)
      0: e = 0;
      1: e = 255;
      2: e = 252 + ($urandom % 3);
      3: e = 1 + ($urandom % 4);
      4: begin
           e = int'(near) + int'($urandom % 61) - 30;
           if (e < 1) e = 1;
           if (e > 254) e = 254;
         end
      default: e = 1 + ($urandom % 254);
    endcase
    return {1'($urandom), 8'(e), 23'($urandom)};
  endfunction

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired: actual %0d pending expected 0", sbq.size());
    report();
  end

  initial begin
    logic [31:0] a, b;
    // R12: reset holds the output quiet
    repeat (4) begin
      @(negedge clk);
      note(out_valid == 1'b0, "R12", "valid in reset", 36'(out_valid), 36'(0));
    end
    rst_n = 1'b1;
    idle(3);
    note(out_valid == 1'b0, "R12", "valid after reset", 36'(out_valid), 36'(0));

    issue(32'h3F800000, 32'h3F800000, 1'b0, 2'b00, "R1 add 1+1");
    issue(32'h40400000, 32'h3F800000, 1'b1, 2'b00, "R1 sub 3-1");
    issue(32'h3F800000, 32'hBF800000, 1'b1, 2'b01, "R1 sub of negative");
    idle(2);
    issue(32'h3F800000, 32'h33800000, 1'b0, 2'b00, "R4 tie to even down");
    issue(32'h3F800001, 32'h33800000, 1'b0, 2'b00, "R4 tie to even up");
    issue(32'h3F800000, 32'h33800001, 1'b0, 2'b00, "R4 above half");
    issue(32'h3F800000, 32'h33800001, 1'b0, 2'b01, "R4 toward zero");
    issue(32'h3F800000, 32'h33000000, 1'b0, 2'b10, "R4 toward +inf");
    issue(32'hBF800000, 32'hB3000000, 1'b0, 2'b11, "R4 toward -inf");
    issue(32'hBF800000, 32'hB3000000, 1'b0, 2'b10, "R4 +inf on negative");
    issue(32'h3F800000, 32'h00400000, 1'b0, 2'b00, "R5 denormal operand");
    issue(32'h00400000, 32'h80400000, 1'b0, 2'b11, "R5 R8 denormals as zeros");
    issue(32'h7FC00001, 32'h3F800000, 1'b0, 2'b00, "R6 NaN operand");
    issue(32'h3F800000, 32'hFF800001, 1'b1, 2'b00, "R6 NaN second");
    issue(32'h7F800000, 32'h7F800000, 1'b1, 2'b00, "R6 inf minus inf");
    issue(32'h7F800000, 32'h7F800000, 1'b0, 2'b00, "R7 inf plus inf");
    issue(32'h3F800000, 32'h7F800000, 1'b1, 2'b00, "R7 one minus inf");
    issue(32'h3F800000, 32'h3F800000, 1'b1, 2'b00, "R8 cancel rne");
    issue(32'h3F800000, 32'h3F800000, 1'b1, 2'b11, "R8 cancel rdn");
    issue(32'h80000000, 32'h00000000, 1'b1, 2'b00, "R8 -0 minus +0");
    issue(32'h00000000, 32'h80000000, 1'b0, 2'b10, "R8 +0 plus -0");
    for (int m = 0; m < 4; m++) begin
      issue(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'(m), "R9 overflow positive");
      issue(32'hFF7FFFFF, 32'hFF000000, 1'b0, 2'(m), "R9 overflow negative");
    end
    issue(32'h7F7FFFFF, 32'h73000000, 1'b0, 2'b00, "R9 rounding to overflow");
    issue(32'h00800001, 32'h00800000, 1'b1, 2'b00, "R10 tiny difference");
    issue(32'h80800000, 32'h00C00000, 1'b0, 2'b01, "R10 tiny negative");
    issue(32'h01000000, 32'h00FFFFFF, 1'b1, 2'b00, "R10 near boundary");
    issue(32'h3FC00000, 32'h3F800000, 1'b1, 2'b00, "R11 exact no inexact");
    idle(5);

    for (int i = 0; i < 3000; i++) begin
      int mode;
      mode = $urandom % 16;
      if (mode < 5) begin
        a = rnd_word(5, 8'd0);
        b = rnd_word(4, a[30:23]);
      end else if (mode < 8) begin
        a = rnd_word(5, 8'd0);
        b = {a[31], a[30:23], a[22:0] ^ 23'($urandom % 64)};
      end else if (mode < 10) begin
        a = rnd_word(2, 8'd0);
        b = rnd_word(2, 8'd0);
      end else if (mode < 12) begin
        a = rnd_word(3, 8'd0);
        b = rnd_word(3, 8'd0);
      end else if (mode == 12) begin
        a = rnd_word(0, 8'd0);
        b = rnd_word(5, 8'd0);
      end else if (mode == 13) begin
        a = rnd_word(1, 8'd0);
        b = rnd_word($urandom % 2 == 0 ? 1 : 5, 8'd0);
      end else begin
        a = rnd_word(5, 8'd0);
        b = rnd_word(5, 8'd0);
      end
      issue(a, b, 1'($urandom), 2'($urandom), "R3 R4 random stream");
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    idle(6);
    note(sbq.size() == 0, "R2", "left in scoreboard", 36'(sbq.size()), 36'(0));
    report();
  end

endmodule